// File: doc/BRIEF.md
# Configurable Integer Shift Unit

This block shifts a 32-bit integer left or right for a small integer core. It does a logical left shift, a logical right shift and an arithmetic right shift. The shift distance comes from the low five bits of a second operand word, and the upper bits of that word are ignored. A build parameter picks how much logic is spent on the shift. The iterative engine moves the word four places per cycle while at least four places remain, then one place per cycle. A cheaper variant moves one place per cycle throughout. The barrel variant finishes in a single cycle and can optionally add one register stage behind the shifter.

The controlling logic raises `start` for one cycle with the operands valid. The unit takes the request on the next rising edge if `busy` is low. `busy` is the only back-pressure: a `start` seen while `busy` is high is dropped, and the caller must hold its request until `busy` falls. `done` pulses for one cycle when `result` carries the new value. `result` then keeps that value until the next operation completes. A zero distance finishes at once in every variant.

Top module: `shift_unit`

## Requirements
- R1: With `op` = 2'b00, `result` equals `operand` shifted left by the distance, and the vacated low bits are zero.
- R2: With `op` = 2'b01 or 2'b10, `result` equals `operand` shifted right by the distance, and the vacated high bits are zero.
- R3: With `op` = 2'b11, `result` equals `operand` shifted right by the distance, and the vacated high bits are copies of `operand` bit 31.
- R4: The distance is `shamt_src[4:0]`. Bits 31..5 of `shamt_src` have no effect on `result` or on timing.
- R5: In the default iterative variant (`BARREL`=0, `COARSE`=1), a request accepted on edge E0 with distance n raises `done` after edge E(floor(n/4) + n mod 4).
- R6: With `BARREL`=0 and `COARSE`=0, `done` rises after edge E(n).
- R7: With `BARREL`=1 and `REG_BARREL`=0, `done` rises after E0 and `busy` never goes high.
- R8: With `BARREL`=1 and `REG_BARREL`=1, a non-zero distance holds `busy` high after E0 and raises `done` after E1.
- R9: A zero distance raises `done` after E0 with `result` equal to `operand`, in every variant.
- R10: While `busy` is high, `start` is ignored, and `busy` falls only in the cycle in which `done` is raised.
- R11: `done` is a one-cycle pulse per accepted request, and `result` changes only when `done` is high.
- R12: A synchronous active-high `rst` clears `busy`, `done` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken when `busy` is low |
| op | input | 2 | Shift kind: 00 left, 01/10 logical right, 11 arithmetic right |
| operand | input | 32 | Word to be shifted |
| shamt_src | input | 32 | Second operand; the low five bits give the distance |
| busy | output | 1 | An accepted request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Last completed result |

## Verification
The checker runs on every cycle. It checks that `busy` and `done` never overlap, that `busy` ends only through `done`, and that `result` stays put between completions. It also checks that a zero distance finishes one edge later with the operand unchanged, that the sign fill and the low zero fill are right at completion, and that the barrel variants meet their exact latencies. The exact shifted values, the iterative cycle counts for each distance, the dropping of a `start` raised mid-operation and the masking of the upper distance bits can only be shown by the scenarios. In those scenarios four builds of the unit run the same requests and are checked against a scoreboard.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  // Shift kinds; both right-logical codes behave alike.
  typedef enum logic [1:0] {
    SH_LEFT    = 2'b00,
    SH_RIGHT_L = 2'b01,
    SH_RIGHT_X = 2'b10,
    SH_RIGHT_A = 2'b11
  } sh_op_e;

  function automatic logic op_is_left(input logic [1:0] op);
    return op == SH_LEFT;
  endfunction

  function automatic logic op_is_arith(input logic [1:0] op);
    return op == SH_RIGHT_A;
  endfunction

endpackage

// File: rtl/shift_unit_barrel.sv
module shift_unit_barrel #(
  parameter int W = 32
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 left,
  input  logic                 arith,
  output logic [W-1:0]         dout
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] stg [SHW+1];
  logic         fill;

  assign fill   = arith & din[W-1];
  assign stg[0] = din;

  // One mux layer per distance bit, layer i moves by 2**i places.
  for (genvar i = 0; i < SHW; i++) begin : g_layer
    localparam int D = 1 << i;
    logic [W-1:0] moved;
    assign moved    = left ? {stg[i][W-1-D:0], {D{1'b0}}}
                           : {{D{fill}}, stg[i][W-1:D]};
    assign stg[i+1] = amt[i] ? moved : stg[i];
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/shift_unit_fast.sv
module shift_unit_fast
  import shift_unit_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [W-1:0]         operand,
  input  logic [$clog2(W)-1:0] amt,
  output logic                 busy,
  output logic                 done,
  output logic [W-1:0]         result
);
  logic [W-1:0] shifted;
  logic         res_left, res_arith;

  assign res_left  = op_is_left(op);
  assign res_arith = op_is_arith(op);

  shift_unit_barrel #(.W(W)) u_barrel (
    .din  (operand),
    .amt  (amt),
    .left (res_left),
    .arith(res_arith),
    .dout (shifted)
  );

  if (REG_OUT) begin : g_staged
    logic [W-1:0] stage_q, res_q;
    logic         busy_q, done_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        res_q   <= '0;
        busy_q  <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        done_q <= 1'b0;
        if (busy_q) begin
          res_q  <= stage_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (start) begin
          if (amt == '0) begin
            res_q  <= operand;
            done_q <= 1'b1;
          end else begin
            stage_q <= shifted;
            busy_q  <= 1'b1;
          end
        end
      end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = res_q;
  end else begin : g_direct
    logic [W-1:0] res_q;
    logic         done_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        res_q  <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= start;
        if (start) res_q <= shifted;
      end
    end

    assign busy   = 1'b0;
    assign done   = done_q;
    assign result = res_q;
  end
endmodule

// File: rtl/shift_unit_iter.sv
module shift_unit_iter
  import shift_unit_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [W-1:0]         operand,
  input  logic [$clog2(W)-1:0] amt,
  output logic                 busy,
  output logic                 done,
  output logic [W-1:0]         result
);
  localparam int SHW = $clog2(W);

  logic [W-1:0]   work_q, work_nx, res_q;
  logic [SHW-1:0] rem_q, step;
  logic           left_q, arith_q, busy_q, done_q;

  // Coarse move while enough distance remains, single places after that.
  always_comb begin
    step = (rem_q >= SHW'(STEP)) ? SHW'(STEP) : SHW'(1);
    if (left_q) work_nx = work_q << step;
    else        work_nx = W'($signed({arith_q & work_q[W-1], work_q}) >>> step);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      res_q   <= '0;
      rem_q   <= '0;
      left_q  <= 1'b0;
      arith_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        work_q <= work_nx;
        rem_q  <= rem_q - step;
        if (rem_q == step) begin
          res_q  <= work_nx;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end else if (start) begin
        if (amt == '0) begin
          res_q  <= operand;
          done_q <= 1'b1;
        end else begin
          work_q  <= operand;
          rem_q   <= amt;
          left_q  <= op_is_left(op);
          arith_q <= op_is_arith(op);
          busy_q  <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W           = 32,
  parameter bit BARREL      = 1'b0,
  parameter bit COARSE      = 1'b1,
  parameter int COARSE_STEP = 4,
  parameter bit REG_BARREL  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] shamt_src,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int SHW       = $clog2(W);
  localparam int ITER_STEP = COARSE ? COARSE_STEP : 1;

  logic [SHW-1:0] amt;
  logic           unused_amt_hi;

  assign amt           = shamt_src[SHW-1:0];
  assign unused_amt_hi = ^shamt_src[W-1:SHW];

  if (BARREL) begin : g_barrel
    shift_unit_fast #(.W(W), .REG_OUT(REG_BARREL)) u_core (
      .clk, .rst, .start, .op, .operand, .amt, .busy, .done, .result
    );
  end else begin : g_iter
    shift_unit_iter #(.W(W), .STEP(ITER_STEP)) u_core (
      .clk, .rst, .start, .op, .operand, .amt, .busy, .done, .result
    );
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W          = 32,
  parameter bit BARREL     = 1'b0,
  parameter bit REG_BARREL = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] operand,
  input logic [W-1:0] shamt_src,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic           accept, pend_neg, pend_lsb0;

  assign amt    = shamt_src[SHW-1:0];
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_neg  <= 1'b0;
      pend_lsb0 <= 1'b0;
    end else if (accept) begin
      pend_neg  <= (op == 2'b11) && operand[W-1];
      pend_lsb0 <= (op == 2'b00) && (amt != '0);
    end
  end

  p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && result == '0));

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_busy_ends_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_zero_amt_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && amt == '0) |=> (done && result == $past(operand)));

  p_sign_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (done && pend_neg) |-> result[W-1]);

  p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (done && pend_lsb0) |-> !result[0]);

  if (BARREL && !REG_BARREL) begin : g_direct
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
      start |=> done);
    p_never_busy_r7: assert property (@(posedge clk) disable iff (rst)
      !busy);
  end

  if (BARREL && REG_BARREL) begin : g_staged
    p_stage_busy_r8: assert property (@(posedge clk) disable iff (rst)
      (accept && amt != '0) |=> (busy && !done));
    p_stage_done_r8: assert property (@(posedge clk) disable iff (rst)
      busy |=> done);
  end
endmodule

bind shift_unit shift_unit_chk #(.W(W), .BARREL(BARREL), .REG_BARREL(REG_BARREL)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
  .shamt_src(shamt_src), .busy(busy), .done(done), .result(result)
);

// File: tb/shift_unit_test.sv
module shift_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   start_v = 4'h0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] operand = '0;
  logic [W-1:0] shsrc = '0;
  logic [W-1:0] res_v  [4];
  logic         busy_v [4];
  logic         done_v [4];

  always #4 clk = ~clk;

  // 0: coarse iterative, 1: single-place iterative, 2: barrel, 3: staged barrel
  shift_unit #(.W(W)) uut (
    .clk, .rst, .start(start_v[0]), .op, .operand, .shamt_src(shsrc),
    .busy(busy_v[0]), .done(done_v[0]), .result(res_v[0]));
  shift_unit #(.W(W), .COARSE(1'b0)) uut_fine (
    .clk, .rst, .start(start_v[1]), .op, .operand, .shamt_src(shsrc),
    .busy(busy_v[1]), .done(done_v[1]), .result(res_v[1]));
  shift_unit #(.W(W), .BARREL(1'b1)) uut_bar (
    .clk, .rst, .start(start_v[2]), .op, .operand, .shamt_src(shsrc),
    .busy(busy_v[2]), .done(done_v[2]), .result(res_v[2]));
  shift_unit #(.W(W), .BARREL(1'b1), .REG_BARREL(1'b1)) uut_barreg (
    .clk, .rst, .start(start_v[3]), .op, .operand, .shamt_src(shsrc),
    .busy(busy_v[3]), .done(done_v[3]), .result(res_v[3]));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [W-1:0] res;
    logic [31:0]  s;
    logic [7:0]   n;
    logic [1:0]   o;
  } item_t;
  item_t exp_q[$];

  logic         seen [4];
  logic [W-1:0] last_res [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input int i, input int n);
    if (n == 0) return 0;
    case (i)
      0:       return n / 4 + n % 4;
      1:       return n;
      2:       return 0;
      default: return 1;
    endcase
  endfunction

  function automatic string lat_req(input int i);
    case (i)
      0:       return "R5";
      1:       return "R6";
      2:       return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic string op_req(input logic [1:0] o, input int n);
    if (n == 0)       return "R9";
    if (o == 2'b00)   return "R1";
    if (o == 2'b11)   return "R3";
    return "R2";
  endfunction

  // Monitor: pops the scoreboard when all four builds have completed.
  always @(negedge clk) begin : mon
    int k;
    int n;
    if (!rst) begin
      for (int i = 0; i < 4; i++) begin
        if (!done_v[i] && res_v[i] !== last_res[i])
          chk(0, "R11", $sformatf("result moved without done, unit %0d", i), res_v[i], last_res[i]);
        last_res[i] = res_v[i];
      end
      if (busy_v[2]) chk(0, "R7", "barrel unit busy", 32'(busy_v[2]), '0);
      if (exp_q.size() > 0) begin
        k = cyc - int'(exp_q[0].s) - 1;
        n = int'(exp_q[0].n);
        if (k == 0) begin
          chk(busy_v[0] == (n != 0), "R10", "busy after accept, coarse", 32'(busy_v[0]), 32'(n != 0));
          chk(busy_v[1] == (n != 0), "R10", "busy after accept, fine", 32'(busy_v[1]), 32'(n != 0));
          chk(busy_v[3] == (n != 0), "R8", "busy after accept, staged", 32'(busy_v[3]), 32'(n != 0));
        end
        if (k >= 0) begin
          for (int i = 0; i < 4; i++) begin
            if (done_v[i]) begin
              if (seen[i]) chk(0, "R11", $sformatf("second done, unit %0d", i), 32'(k), '0);
              else begin
                chk(res_v[i] === exp_q[0].res, op_req(exp_q[0].o, n),
                    $sformatf("result unit %0d n=%0d", i, n), res_v[i], exp_q[0].res);
                chk(k == lat_of(i, n), lat_req(i),
                    $sformatf("latency unit %0d n=%0d", i, n), 32'(k), 32'(lat_of(i, n)));
                seen[i] = 1'b1;
              end
            end
          end
          if (seen[0] && seen[1] && seen[2] && seen[3]) begin
            void'(exp_q.pop_front());
            for (int i = 0; i < 4; i++) seen[i] = 1'b0;
          end
        end
      end else begin
        for (int i = 0; i < 4; i++)
          if (done_v[i]) chk(0, "R11", $sformatf("done with nothing pending, unit %0d", i), 32'(done_v[i]), '0);
      end
    end
  end

  // Driver: pushes the expected item, pulses start, optionally raises a
  // second start on the iterative units while they are busy (R10).
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] src, input bit inject);
    item_t it;
    int n;
    logic [W-1:0] e;
    n = int'(src[4:0]);
    case (o)
      2'b00:   e = a << n;
      2'b11:   e = W'($signed(a) >>> n);
      default: e = a >> n;
    endcase
    @(negedge clk);
    op = o; operand = a; shsrc = src; start_v = 4'hF;
    it.res = e; it.s = 32'(cyc); it.n = 8'(n); it.o = o;
    exp_q.push_back(it);
    @(negedge clk);
    start_v = 4'h0;
    if (inject) begin
      @(negedge clk);
      op = ~o; operand = ~a; shsrc = src + 32'd3; start_v = 4'b0011;
      @(negedge clk);
      start_v = 4'h0;
    end
    for (int t = 0; t < 100 && exp_q.size() != 0; t++) @(negedge clk);
    if (exp_q.size() != 0) begin
      chk(0, "R5", "operation never completed", 32'(exp_q.size()), '0);
      exp_q.delete();
      for (int i = 0; i < 4; i++) seen[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run did not end", 32'(cyc), '0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      seen[i] = 1'b0;
      last_res[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(!busy_v[i] && !done_v[i], "R12", $sformatf("busy/done after reset, unit %0d", i),
          32'({busy_v[i], done_v[i]}), '0);
      chk(res_v[i] === '0, "R12", $sformatf("result after reset, unit %0d", i), res_v[i], '0);
    end

    run_op(2'b00, 32'h8000_0001, 32'd1, 1'b0);      // R1
    run_op(2'b00, 32'h1234_5678, 32'd4, 1'b0);      // R1, R5 exact coarse step
    run_op(2'b00, 32'h1234_5678, 32'd5, 1'b0);      // R1, R5 coarse then fine
    run_op(2'b00, 32'hFFFF_FFFF, 32'd31, 1'b0);     // R1 longest
    run_op(2'b01, 32'hF000_000F, 32'd7, 1'b0);      // R2
    run_op(2'b10, 32'h8000_0000, 32'd16, 1'b0);     // R2 alternate code
    run_op(2'b11, 32'h8765_4321, 32'd3, 1'b0);      // R3 negative
    run_op(2'b11, 32'h8000_0000, 32'd31, 1'b0);     // R3 all ones
    run_op(2'b11, 32'h7000_0000, 32'd8, 1'b0);      // R3 positive
    run_op(2'b00, 32'hDEAD_BEEF, 32'd0, 1'b0);      // R9
    run_op(2'b11, 32'h9ABC_DEF0, 32'h0000_0020, 1'b0); // R4, R9: distance bits zero
    run_op(2'b11, 32'hC000_1234, 32'hFFFF_FFE3, 1'b0); // R4 upper bits set
    run_op(2'b01, 32'hC000_1234, 32'h0000_0FE3, 1'b0); // R4
    run_op(2'b00, 32'h0000_00FF, 32'd13, 1'b1);     // R10 start while busy
    run_op(2'b11, 32'h8000_0F00, 32'd31, 1'b1);     // R10 start while busy

    chk(exp_q.size() == 0, "R11", "scoreboard drained", 32'(exp_q.size()), '0);
    finish_run();
  end
endmodule